// File: doc/BRIEF.md
# Link Character Receiver and Checker

This block sits behind the receive side of a synchronous, parallel point-to-point link. In any cycle where the valid strobe is high it takes one link word. The word holds a parity bit in the top position, a data/control flag below it, and a payload of `DW` bits. The block sorts each word into one of six kinds: data, end of packet, error end of packet, flow-control token, escape, or the idle pair made of escape followed by flow-control token. It checks odd parity, and the parity bit reaches back across the boundary into the previous character. It also checks that each character is legal in the current link state.

Normal characters, meaning data and the two packet markers, go to a receive FIFO write port. Before a normal character is written, the block checks three things: the link is running, the FIFO has room, and the far end was granted credit for it. Each flow-control token that arrives adds eight characters to the credit for the local transmitter, up to a ceiling of seven tokens. The block also keeps its own count of characters it has granted. The local transmitter raises a strobe each time it sends a token, and that count goes up by eight.

Five error strobes report to the link state machine: parity, escape, disconnect, character and flow-control. The disconnect strobe fires after a programmable run of idle cycles, once the link has carried its first character.

Top module: `lrx_char_rx`

## Requirements
- R1: A word is `{parity, flag, payload}`. The count of ones over the previous character's payload (all `DW` data bits, or only its two low control bits), the current flag and the current parity bit must be odd. If it is not, `err_par` pulses and the word has no other effect. The first character after reset, or after link state 0, is checked against an all-zero history.
- R2: In link state 5 (run), a data word (flag 0) with credit available and `fifo_full` low writes `{1'b0, payload}`. The write appears on `wr_en`/`wr_data` one cycle after the word.
- R3: A control word (flag 1) carries its code in payload bits [1:0]: 00 flow-control token, 01 end of packet, 10 error end of packet, 11 escape. End of packet is written as `{1'b1, all zeros}`. Error end of packet is written as `{1'b1, zeros, 1'b1}`.
- R4: Escape followed by a flow-control token pulses `got_null` and leaves the credits unchanged. Escape followed by any other word pulses `err_esc`.
- R5: A flow-control token in link state 4 or 5 pulses `got_fct` and adds 8 to `tx_credit`. If `tx_credit` is above 48 at that point, `err_fct` pulses and `tx_credit` stays at its ceiling of 56.
- R6: `tx_used` lowers `tx_credit` by one when `tx_credit` is nonzero.
- R7: `fct_sent` adds 8 to `rx_grant`, but is ignored if the sum would exceed 56. Every written character lowers `rx_grant` by one. Both changes can happen in the same cycle.
- R8: A normal character that arrives while `rx_grant` is zero or `fifo_full` is high pulses `err_char` and is not written.
- R9: A normal character outside link state 5, or a flow-control token in link states 1 to 3, pulses `err_char`.
- R10: The link is armed by its first valid word after leaving state 0. Once armed, `DSC_CYCLES` consecutive edges without a valid word raise one `err_dsc` pulse. Before the link is armed, idle cycles raise nothing.
- R11: Link state 0 holds the receiver in reset. Both credits, the pending escape, the parity history and the disconnect arming are cleared, and words are ignored.
- R12: Every output is registered. In any cycle at most one of the write and result strobes is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_state | input | 3 | Link state: 0 reset, 1 wait, 2 ready, 3 started, 4 connecting, 5 run |
| rx_valid | input | 1 | Link word valid |
| rx_word | input | DW+2 | Link word `{parity, flag, payload}` |
| fifo_full | input | 1 | Receive FIFO cannot take a word |
| fct_sent | input | 1 | Local transmitter sent a flow-control token |
| tx_used | input | 1 | Local transmitter spent one character of credit |
| wr_en | output | 1 | Receive FIFO write strobe |
| wr_data | output | DW+1 | FIFO word `{flag, payload}` |
| got_null | output | 1 | Idle pair received |
| got_fct | output | 1 | Flow-control token accepted |
| err_par | output | 1 | Parity error |
| err_esc | output | 1 | Escape error |
| err_dsc | output | 1 | Disconnect error |
| err_char | output | 1 | Character error |
| err_fct | output | 1 | Flow-control credit error |
| tx_credit | output | CRED_W | Characters the local transmitter may send |
| rx_grant | output | CRED_W | Characters granted to the far end but not yet received |

## Verification
The bench builds the block with `DW` = 8 and the default credit of eight characters per token with a seven-token ceiling. This makes the 48 and 56 credit boundaries reachable in a few dozen words. `DSC_CYCLES` is cut to 12, so the disconnect window can be walked edge by edge, one cycle short and exactly at the limit. Parity is chosen so that a history left uncleared by link state 0 shows up as a parity error.

// File: rtl/lrx_pkg.sv
package lrx_pkg;

  typedef enum logic [2:0] {
    LS_RESET      = 3'd0,
    LS_WAIT       = 3'd1,
    LS_READY      = 3'd2,
    LS_STARTED    = 3'd3,
    LS_CONNECTING = 3'd4,
    LS_RUN        = 3'd5
  } link_state_e;

  localparam logic [1:0] CC_FCT = 2'b00;
  localparam logic [1:0] CC_EOP = 2'b01;
  localparam logic [1:0] CC_EEP = 2'b10;
  localparam logic [1:0] CC_ESC = 2'b11;

  localparam int CTRL_W = 2;

  typedef enum logic [2:0] {
    RES_NONE,
    RES_WRITE,
    RES_NULL,
    RES_FCT,
    RES_EPAR,
    RES_EESC,
    RES_ECHAR,
    RES_EFCT
  } rx_result_e;

endpackage

// File: rtl/lrx_parity.sv
// Odd-parity check whose coverage spans the previous payload and the current flag.
module lrx_parity #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          valid,
  input  logic          flag,
  input  logic          par,
  input  logic [DW-1:0] payload,
  output logic          par_err
);
  import lrx_pkg::*;

  logic [DW-1:0] history;
  logic [DW-1:0] ctrl_ext;

  // A control character contributes only its code bits to the next check.
  generate
    if (DW > CTRL_W) begin : g_ext
      assign ctrl_ext = {{(DW-CTRL_W){1'b0}}, payload[CTRL_W-1:0]};
    end else begin : g_narrow
      assign ctrl_ext = payload;
    end
  endgenerate

  assign par_err = valid && !(^{history, flag, par});

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      history <= '0;
    end else if (valid) begin
      history <= flag ? ctrl_ext : payload;
    end
  end

endmodule

// File: rtl/lrx_credit.sv
// Credit counter: rises by STEP while there is room, falls by one while nonzero.
module lrx_credit #(
  parameter int STEP  = 8,
  parameter int LIMIT = 56,
  parameter int W     = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] count,
  output logic         room,
  output logic         avail
);
  localparam logic [W-1:0] STEP_V   = W'(STEP);
  localparam logic [W-1:0] ROOM_TOP = W'(LIMIT - STEP);

  assign room  = (count <= ROOM_TOP);
  assign avail = (count != '0);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else begin
      count <= count + ((inc && room) ? STEP_V : '0)
                     - ((dec && avail) ? W'(1) : '0);
    end
  end

endmodule

// File: rtl/lrx_disc_timer.sv
// Inactivity watchdog, armed by the first valid word.
module lrx_disc_timer #(
  parameter int LIMIT = 85,
  parameter int W     = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic valid,
  output logic err
);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic         armed;
  logic [W-1:0] idle_cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      armed    <= 1'b0;
      idle_cnt <= '0;
      err      <= 1'b0;
    end else begin
      err <= 1'b0;
      if (valid) begin
        armed    <= 1'b1;
        idle_cnt <= '0;
      end else if (armed) begin
        if (idle_cnt == LAST) begin
          err      <= 1'b1;
          armed    <= 1'b0;
          idle_cnt <= '0;
        end else begin
          idle_cnt <= idle_cnt + W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/lrx_char_rx.sv
module lrx_char_rx #(
  parameter int DW         = 8,
  parameter int DSC_CYCLES = 85,
  parameter int FCT_CHARS  = 8,
  parameter int MAX_FCT    = 7,
  parameter int CRED_W     = $clog2(MAX_FCT * FCT_CHARS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        link_state,
  input  logic              rx_valid,
  input  logic [DW+1:0]     rx_word,
  input  logic              fifo_full,
  input  logic              fct_sent,
  input  logic              tx_used,
  output logic              wr_en,
  output logic [DW:0]       wr_data,
  output logic              got_null,
  output logic              got_fct,
  output logic              err_par,
  output logic              err_esc,
  output logic              err_dsc,
  output logic              err_char,
  output logic              err_fct,
  output logic [CRED_W-1:0] tx_credit,
  output logic [CRED_W-1:0] rx_grant
);
  import lrx_pkg::*;

  localparam int MAX_CRED = MAX_FCT * FCT_CHARS;

  link_state_e lstate;
  logic        enabled;
  logic        in_run;
  logic        fct_legal;
  logic        word_par;
  logic        word_flag;
  logic [DW-1:0] word_pay;
  logic [1:0]  word_code;

  assign lstate    = link_state_e'(link_state);
  assign enabled   = (lstate != LS_RESET);
  assign in_run    = (lstate == LS_RUN);
  assign fct_legal = (lstate == LS_CONNECTING) || (lstate == LS_RUN);

  assign word_par  = rx_word[DW+1];
  assign word_flag = rx_word[DW];
  assign word_pay  = rx_word[DW-1:0];
  assign word_code = word_pay[1:0];

  logic word_in;
  assign word_in = enabled && rx_valid;

  // Parity
  logic par_err;

  lrx_parity #(.DW(DW)) u_parity (
    .clk     (clk),
    .rst     (rst),
    .clr     (!enabled),
    .valid   (word_in),
    .flag    (word_flag),
    .par     (word_par),
    .payload (word_pay),
    .par_err (par_err)
  );

  // Credits
  rx_result_e res;
  logic       tx_room;
  logic       tx_avail;
  logic       rx_room;
  logic       rx_avail;

  lrx_credit #(.STEP(FCT_CHARS), .LIMIT(MAX_CRED), .W(CRED_W)) u_tx_credit (
    .clk   (clk),
    .rst   (rst),
    .clr   (!enabled),
    .inc   (res == RES_FCT),
    .dec   (tx_used),
    .count (tx_credit),
    .room  (tx_room),
    .avail (tx_avail)
  );

  lrx_credit #(.STEP(FCT_CHARS), .LIMIT(MAX_CRED), .W(CRED_W)) u_rx_grant (
    .clk   (clk),
    .rst   (rst),
    .clr   (!enabled),
    .inc   (fct_sent),
    .dec   (res == RES_WRITE),
    .count (rx_grant),
    .room  (rx_room),
    .avail (rx_avail)
  );

  // Disconnect detection
  lrx_disc_timer #(.LIMIT(DSC_CYCLES)) u_disc (
    .clk   (clk),
    .rst   (rst),
    .clr   (!enabled),
    .valid (word_in),
    .err   (err_dsc)
  );

  // Classification
  logic esc_pend;
  logic esc_nxt;

  always_comb begin
    res     = RES_NONE;
    esc_nxt = esc_pend;
    if (word_in) begin
      if (par_err) begin
        res     = RES_EPAR;
        esc_nxt = 1'b0;
      end else if (esc_pend) begin
        esc_nxt = 1'b0;
        res     = (word_flag && word_code == CC_FCT) ? RES_NULL : RES_EESC;
      end else if (word_flag && word_code == CC_ESC) begin
        esc_nxt = 1'b1;
      end else if (word_flag && word_code == CC_FCT) begin
        if (!fct_legal)    res = RES_ECHAR;
        else if (!tx_room) res = RES_EFCT;
        else               res = RES_FCT;
      end else begin
        if (!in_run || fifo_full || !rx_avail) res = RES_ECHAR;
        else                                   res = RES_WRITE;
      end
    end
  end

  logic [DW:0] wdata_nxt;

  always_comb begin
    if (!word_flag) begin
      wdata_nxt = {1'b0, word_pay};
    end else begin
      wdata_nxt = {1'b1, {(DW-1){1'b0}}, (word_code == CC_EEP)};
    end
  end

  // Registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      esc_pend <= 1'b0;
      wr_en    <= 1'b0;
      wr_data  <= '0;
      got_null <= 1'b0;
      got_fct  <= 1'b0;
      err_par  <= 1'b0;
      err_esc  <= 1'b0;
      err_char <= 1'b0;
      err_fct  <= 1'b0;
    end else begin
      esc_pend <= enabled ? esc_nxt : 1'b0;
      wr_en    <= (res == RES_WRITE);
      got_null <= (res == RES_NULL);
      got_fct  <= (res == RES_FCT);
      err_par  <= (res == RES_EPAR);
      err_esc  <= (res == RES_EESC);
      err_char <= (res == RES_ECHAR);
      err_fct  <= (res == RES_EFCT);
      if (res == RES_WRITE) wr_data <= wdata_nxt;
    end
  end

endmodule

// File: rtl/lrx_char_rx_chk.sv
module lrx_char_rx_chk #(
  parameter int FCT_CHARS = 8,
  parameter int MAX_CRED  = 56,
  parameter int CRED_W    = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        link_state,
  input logic              rx_valid,
  input logic              fifo_full,
  input logic              wr_en,
  input logic              got_null,
  input logic              got_fct,
  input logic              err_par,
  input logic              err_esc,
  input logic              err_dsc,
  input logic              err_char,
  input logic              err_fct,
  input logic [CRED_W-1:0] tx_credit,
  input logic [CRED_W-1:0] rx_grant
);

  // R12
  onehot_out_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_en, got_null, got_fct, err_par, err_esc, err_dsc, err_char, err_fct}));

  // R5
  tx_credit_max_chk: assert property (@(posedge clk) disable iff (rst)
    tx_credit <= CRED_W'(MAX_CRED));

  // R5
  fct_credit_chk: assert property (@(posedge clk) disable iff (rst)
    got_fct |-> tx_credit >= CRED_W'(FCT_CHARS - 1));

  // R7
  rx_grant_max_chk: assert property (@(posedge clk) disable iff (rst)
    rx_grant <= CRED_W'(MAX_CRED));

  // R9
  write_in_run_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(link_state) == 3'd5);

  // R8
  no_write_full_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !$past(fifo_full));

  // R10
  dsc_idle_chk: assert property (@(posedge clk) disable iff (rst)
    err_dsc |-> !$past(rx_valid));

  // R11
  hold_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (link_state == 3'd0) |=> (tx_credit == '0 && rx_grant == '0 && !wr_en && !got_fct));

endmodule

bind lrx_char_rx lrx_char_rx_chk #(
  .FCT_CHARS (FCT_CHARS),
  .MAX_CRED  (MAX_FCT * FCT_CHARS),
  .CRED_W    (CRED_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .link_state (link_state),
  .rx_valid   (rx_valid),
  .fifo_full  (fifo_full),
  .wr_en      (wr_en),
  .got_null   (got_null),
  .got_fct    (got_fct),
  .err_par    (err_par),
  .err_esc    (err_esc),
  .err_dsc    (err_dsc),
  .err_char   (err_char),
  .err_fct    (err_fct),
  .tx_credit  (tx_credit),
  .rx_grant   (rx_grant)
);

// File: tb/tb_lrx_char_rx.sv
module tb_lrx_char_rx;

  localparam int K_NONE = 0, K_WR = 1, K_NULL = 2, K_FCT = 3, K_PAR = 4,
                 K_ESC = 5, K_CHR = 6, K_FE = 7, K_DSC = 8, K_MULTI = 99;
  localparam logic [7:0] P_FCT = 8'h00, P_EOP = 8'h01, P_EEP = 8'h02, P_ESC = 8'h03;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] link_state = 3'd0;
  logic       rx_valid = 1'b0;
  logic [9:0] rx_word = '0;
  logic       fifo_full = 1'b0;
  logic       fct_sent = 1'b0;
  logic       tx_used = 1'b0;
  logic       wr_en;
  logic [8:0] wr_data;
  logic       got_null, got_fct, err_par, err_esc, err_dsc, err_char, err_fct;
  logic [5:0] tx_credit, rx_grant;

  always #2.5 clk = ~clk;

  lrx_char_rx #(.DW(8), .DSC_CYCLES(12)) dut (
    .clk(clk), .rst(rst), .link_state(link_state), .rx_valid(rx_valid),
    .rx_word(rx_word), .fifo_full(fifo_full), .fct_sent(fct_sent), .tx_used(tx_used),
    .wr_en(wr_en), .wr_data(wr_data), .got_null(got_null), .got_fct(got_fct),
    .err_par(err_par), .err_esc(err_esc), .err_dsc(err_dsc), .err_char(err_char),
    .err_fct(err_fct), .tx_credit(tx_credit), .rx_grant(rx_grant)
  );

  typedef struct {
    int         kind;
    logic [8:0] data;
    int         tc;
    int         rg;
    string      req;
  } exp_t;

  exp_t       q[$];
  int         checks = 0;
  int         fails  = 0;
  logic [2:0] ls = 3'd0;
  logic [7:0] prev = '0;
  bit         done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Driver: one link cycle, expectation pushed to the scoreboard.
  task automatic step(input bit v, input bit f, input logic [7:0] pay, input bit bad,
                      input bit fs, input bit tu, input bit full,
                      input int ek, input logic [8:0] ed, input int etc, input int erg,
                      input string req);
    logic p;
    exp_t e;
    @(negedge clk);
    link_state = ls;
    rx_valid   = v;
    p = ~((^prev) ^ f);
    if (bad) p = ~p;
    rx_word = {p, f, pay};
    if (ls == 3'd0)  prev = '0;
    else if (v)      prev = f ? {6'b0, pay[1:0]} : pay;
    fifo_full = full;
    fct_sent  = fs;
    tx_used   = tu;
    e.kind = ek; e.data = ed; e.tc = etc; e.rg = erg; e.req = req;
    q.push_back(e);
  endtask

  task automatic idle(input int ek, input int etc, input int erg, input string req);
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, ek, 9'h0, etc, erg, req);
  endtask

  task automatic dat(input logic [7:0] d, input bit fs, input bit full,
                     input int ek, input int etc, input int erg, input string req);
    step(1'b1, 1'b0, d, 1'b0, fs, 1'b0, full, ek, {1'b0, d}, etc, erg, req);
  endtask

  task automatic ctl(input logic [7:0] c, input bit fs, input bit tu,
                     input int ek, input logic [8:0] ed, input int etc, input int erg,
                     input string req);
    step(1'b1, 1'b1, c, 1'b0, fs, tu, 1'b0, ek, ed, etc, erg, req);
  endtask

  // Monitor: compares the outputs after each edge with the queued expectation.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        int   k;
        int   n;
        e = q.pop_front();
        n = int'(wr_en) + int'(got_null) + int'(got_fct) + int'(err_par) + int'(err_esc)
          + int'(err_char) + int'(err_fct) + int'(err_dsc);
        if (n > 1)         k = K_MULTI;
        else if (wr_en)    k = K_WR;
        else if (got_null) k = K_NULL;
        else if (got_fct)  k = K_FCT;
        else if (err_par)  k = K_PAR;
        else if (err_esc)  k = K_ESC;
        else if (err_char) k = K_CHR;
        else if (err_fct)  k = K_FE;
        else if (err_dsc)  k = K_DSC;
        else               k = K_NONE;
        chk(k == e.kind, e.req, "result kind", k, e.kind);
        if (e.kind == K_WR && k == K_WR)
          chk(wr_data == e.data, e.req, "wr_data", int'(wr_data), int'(e.data));
        chk(int'(tx_credit) == e.tc, e.req, "tx_credit", int'(tx_credit), e.tc);
        chk(int'(rx_grant) == e.rg, e.req, "rx_grant", int'(rx_grant), e.rg);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!wr_en && !got_null && !got_fct && !err_par && !err_esc && !err_dsc
        && !err_char && !err_fct, "R12", "strobes in reset", 1, 0);
    chk(tx_credit == 0 && rx_grant == 0, "R12", "counts in reset",
        int'(tx_credit) + int'(rx_grant), 0);
    rst = 1'b0;

    // R11: held in reset, words ignored
    ls = 3'd0;
    idle(K_NONE, 0, 0, "R11");
    dat(8'h55, 1'b0, 1'b0, K_NONE, 0, 0, "R11");

    // R4: idle pair while waiting
    ls = 3'd1;
    ctl(P_ESC, 0, 0, K_NONE, 9'h0, 0, 0, "R4");
    ctl(P_FCT, 0, 0, K_NULL, 9'h0, 0, 0, "R4");

    // R9: tokens and data too early
    ls = 3'd3;
    ctl(P_FCT, 0, 0, K_CHR, 9'h0, 0, 0, "R9");
    dat(8'h12, 1'b0, 1'b0, K_CHR, 0, 0, "R9");
    ls = 3'd4;
    ctl(P_FCT, 0, 0, K_FCT, 9'h0, 8, 0, "R5");
    dat(8'h34, 1'b0, 1'b0, K_CHR, 8, 0, "R9");

    // Run: credit and writes
    ls = 3'd5;
    dat(8'hA5, 1'b0, 1'b0, K_CHR, 8, 0, "R8");
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, K_NONE, 9'h0, 8, 8, "R7");
    dat(8'hA5, 1'b0, 1'b0, K_WR, 8, 7, "R2");
    ctl(P_EOP, 0, 0, K_WR, 9'h100, 8, 6, "R3");
    ctl(P_EEP, 0, 0, K_WR, 9'h101, 8, 5, "R3");
    dat(8'h3C, 1'b0, 1'b1, K_CHR, 8, 5, "R8");
    dat(8'h3C, 1'b1, 1'b0, K_WR, 8, 12, "R7");

    // R1: parity
    step(1'b1, 1'b0, 8'h77, 1'b1, 1'b0, 1'b0, 1'b0, K_PAR, 9'h0, 8, 12, "R1");
    dat(8'h0F, 1'b0, 1'b0, K_WR, 8, 11, "R1");
    ctl(P_EOP, 0, 0, K_WR, 9'h100, 8, 10, "R1");
    dat(8'h80, 1'b0, 1'b0, K_WR, 8, 9, "R1");

    // R5: fill transmit credit to its ceiling
    for (int i = 2; i <= 7; i++) ctl(P_FCT, 0, 0, K_FCT, 9'h0, 8 * i, 9, "R5");
    ctl(P_FCT, 0, 0, K_FE, 9'h0, 56, 9, "R5");

    // R6: spend credit down to 48
    for (int i = 0; i < 4; i++) begin
      ctl(P_ESC, 0, 1, K_NONE, 9'h0, 55 - 2 * i, 9, "R6");
      ctl(P_FCT, 0, 1, K_NULL, 9'h0, 54 - 2 * i, 9, "R6");
    end
    ctl(P_FCT, 0, 0, K_FCT, 9'h0, 56, 9, "R5");

    // R7: grants up to the ceiling, then an ignored one
    ctl(P_ESC, 1, 0, K_NONE, 9'h0, 56, 17, "R7");
    ctl(P_FCT, 1, 0, K_NULL, 9'h0, 56, 25, "R7");
    ctl(P_ESC, 1, 0, K_NONE, 9'h0, 56, 33, "R7");
    ctl(P_FCT, 1, 0, K_NULL, 9'h0, 56, 41, "R7");
    ctl(P_ESC, 1, 0, K_NONE, 9'h0, 56, 49, "R7");
    ctl(P_FCT, 1, 0, K_NULL, 9'h0, 56, 49, "R7");

    // R4: escape errors
    ctl(P_ESC, 0, 0, K_NONE, 9'h0, 56, 49, "R4");
    ctl(P_EOP, 0, 0, K_ESC, 9'h0, 56, 49, "R4");
    ctl(P_ESC, 0, 0, K_NONE, 9'h0, 56, 49, "R4");
    ctl(P_ESC, 0, 0, K_ESC, 9'h0, 56, 49, "R4");

    // R10: disconnect window
    for (int i = 1; i <= 11; i++) idle(K_NONE, 56, 49, "R10");
    idle(K_DSC, 56, 49, "R10");
    for (int i = 0; i < 3; i++) idle(K_NONE, 56, 49, "R10");

    // R11: parity history and escape cleared by the hold state
    dat(8'h01, 1'b0, 1'b0, K_WR, 56, 48, "R11");
    ls = 3'd0;
    idle(K_NONE, 0, 0, "R11");
    ls = 3'd5;
    dat(8'h02, 1'b0, 1'b0, K_CHR, 0, 0, "R11");
    ctl(P_ESC, 0, 0, K_NONE, 9'h0, 0, 0, "R11");
    ls = 3'd0;
    idle(K_NONE, 0, 0, "R11");
    ls = 3'd5;
    ctl(P_FCT, 0, 0, K_FCT, 9'h0, 8, 0, "R11");

    // R10: not armed before the first word
    ls = 3'd0;
    idle(K_NONE, 0, 0, "R10");
    ls = 3'd1;
    for (int i = 0; i < 15; i++) idle(K_NONE, 0, 0, "R10");

    repeat (3) @(posedge clk);
    #2;
    chk(q.size() == 0, "R12", "scoreboard drained", q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule